// File: doc/BRIEF.md
# Interrupt Redirection Table Register Front End

This block is the software-visible register face of an I/O interrupt redirection controller. Software reaches all internal state through two bus locations: a select register that names a target, and a data window that reads or writes whatever the select register currently names. The targets are a small identification register, a read-only version word, and one 64-bit redirection entry per input pin. Each entry is reached as two 32-bit halves. A third bus location, written directly, issues an end-of-interrupt (EOI) notice for a vector. The EOI location exists only when the controller is built as the newer of its two legal versions.

The full table drives a flat output bus that feeds the delivery engine. That engine owns two status bits in every entry: delivery status, which it supplies as a level, and remote IRR, which it sets and clears with pulses. Software writes cannot change these bits. One exception applies: any software write that leaves an entry edge-triggered forces its remote IRR to zero.

Bus offsets: select at 0x00, data window at 0x10, EOI at 0x40. Size code: 0 = byte, 1 = halfword, 2 = word. Writes take effect at the clock edge where `wr_i` is high. Reads are combinational from the current address and state.

Top module: `irq_route_regs`

## Requirements
- R1: The select register (8 bits) is written and read back at offset 0x00. It is unchanged except by a write to that offset, and it resets to 0.
- R2: Select value 0 targets the ID register. A window write stores bits 27:24 of the data. A window read returns those 4 bits at 27:24 with every other bit zero. The ID resets to 0.
- R3: Select value 1 targets the version word. It reads as the version byte in bits 7:0 and the pin count minus one in bits 23:16, with other bits zero. Writes to it are ignored.
- R4: Select value 0x10+2n targets bits 31:0 of entry n, and 0x10+2n+1 targets bits 63:32. A write to one half leaves the other half unchanged.
- R5: Entry bit 12 (delivery status) follows `dstat_i[n]` one cycle later. Entry bit 14 (remote IRR) is set by a `rirr_set_i[n]` pulse and cleared by a `rirr_clr_i[n]` pulse; set wins when both occur. Software data written to bits 12 and 14 has no effect on them.
- R6: After any software write to an entry, if the entry's trigger bit 15 is 0 (edge), its remote IRR bit 14 is 0.
- R7: With version 0x20, a word-size (size 2) write at offset 0x40 raises `eoi_valid_o` for one cycle at the next edge, with `eoi_vector_o` equal to data bits 7:0. Other sizes produce no EOI. A build with version 0x11 never raises `eoi_valid_o`.
- R8: Select values that name no ID, version or existing entry read as zero through the window, and window writes to them change no state.
- R9: On reset, every entry holds only its mask bit 16 set (0x0000_0000_0001_0000).
- R10: Entry n appears at `tbl_o[64n+63:64n]` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Bus byte offset |
| wdata_i | input | 32 | Bus write data |
| wr_i | input | 1 | Write enable |
| size_i | input | 2 | Access size code (0 byte, 1 half, 2 word) |
| rdata_o | output | 32 | Bus read data |
| rirr_set_i | input | 24 | Per-pin remote IRR set pulses |
| rirr_clr_i | input | 24 | Per-pin remote IRR clear pulses |
| dstat_i | input | 24 | Per-pin delivery status levels |
| tbl_o | output | 1536 | Flattened redirection table |
| eoi_valid_o | output | 1 | EOI strobe |
| eoi_vector_o | output | 8 | Vector for the EOI |

## Verification
If the select decode is wrong, a window read on the very next cycle returns data from the wrong target or zero. A corrupted entry shows on `tbl_o` at the edge after the write and can be confirmed through the window. A remote IRR bit that should have been protected or cleared is visible as bit 14 on the first read after the write or pulse. A faulty EOI gate shows as a strobe that is missing, present when it should not be, or carrying the wrong vector, exactly one edge after the EOI write.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
   localparam int unsigned ENT_W     = 64;
   localparam int unsigned BIT_DSTAT = 12;
   localparam int unsigned BIT_RIRR  = 14;
   localparam int unsigned BIT_TRIG  = 15;
   localparam int unsigned BIT_MASK  = 16;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   localparam logic [ENT_W-1:0] ENT_RESET = ENT_W'(1) << BIT_MASK;
endpackage

// File: rtl/irq_route_sel_dec.sv
module irq_route_sel_dec #(
   parameter int unsigned SEL_W    = 8,
   parameter int unsigned TBL_BASE = 16,
   parameter int unsigned NPINS    = 24,
   parameter int unsigned IDX_W    = 5
) (
   input  logic [SEL_W-1:0] sel_i,
   output logic             is_id_o,
   output logic             is_ver_o,
   output logic             is_ent_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             upper_o
);
   localparam logic [SEL_W-1:0] BASE_V = SEL_W'(TBL_BASE);
   localparam logic [SEL_W-1:0] PINS_V = SEL_W'(NPINS);

   logic [SEL_W-1:0] off;
   logic [SEL_W-1:0] slot;

   always_comb begin
      off      = sel_i - BASE_V;
      slot     = {1'b0, off[SEL_W-1:1]};
      is_id_o  = (sel_i == '0);
      is_ver_o = (sel_i == SEL_W'(1));
      is_ent_o = (sel_i >= BASE_V) && (slot < PINS_V);
      idx_o    = slot[IDX_W-1:0];
      upper_o  = off[0];
   end
endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
   import irq_route_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_lo_i,
   input  logic             we_hi_i,
   input  logic [31:0]      wdata_i,
   input  logic             rirr_set_i,
   input  logic             rirr_clr_i,
   input  logic             dstat_i,
   output logic [ENT_W-1:0] q_o
);
   logic [ENT_W-1:0] merged;
   logic [ENT_W-1:0] nxt;
   logic             rirr_nxt;
   logic             sw_we;

   assign sw_we = we_lo_i | we_hi_i;

   always_comb begin
      merged = q_o;
      if (we_lo_i) merged[31:0]  = wdata_i;
      if (we_hi_i) merged[63:32] = wdata_i;
      // status bits are owned by the delivery engine, never by software
      rirr_nxt = rirr_set_i | (q_o[BIT_RIRR] & ~rirr_clr_i);
      if (sw_we && !merged[BIT_TRIG]) rirr_nxt = 1'b0;
      nxt            = merged;
      nxt[BIT_RIRR]  = rirr_nxt;
      nxt[BIT_DSTAT] = dstat_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= ENT_RESET;
      else        q_o <= nxt;
   end

   AST_EDGE_CLEARS_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
      sw_we |=> (!q_o[BIT_TRIG] -> !q_o[BIT_RIRR])); // R6
   AST_SW_NO_RIRR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_we && !rirr_set_i && !q_o[BIT_RIRR]) |=> !q_o[BIT_RIRR]); // R5
   AST_DSTAT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      dstat_i |=> q_o[BIT_DSTAT]); // R5
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
   import irq_route_pkg::*;
#(
   parameter int unsigned NPINS    = 24,
   parameter logic [7:0]  VERSION  = 8'h20,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned SEL_W    = 8,
   parameter int unsigned TBL_BASE = 16,
   parameter int unsigned ID_LSB   = 24,
   parameter int unsigned ID_W     = 4,
   parameter int unsigned CNT_LSB  = 16,
   parameter int unsigned OFS_SEL  = 'h00,
   parameter int unsigned OFS_WIN  = 'h10,
   parameter int unsigned OFS_EOI  = 'h40
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      addr_i,
   input  logic [31:0]            wdata_i,
   input  logic                   wr_i,
   input  logic [1:0]             size_i,
   output logic [31:0]            rdata_o,
   input  logic [NPINS-1:0]       rirr_set_i,
   input  logic [NPINS-1:0]       rirr_clr_i,
   input  logic [NPINS-1:0]       dstat_i,
   output logic [NPINS*ENT_W-1:0] tbl_o,
   output logic                   eoi_valid_o,
   output logic [7:0]             eoi_vector_o
);
   localparam int unsigned IDX_W = $clog2(NPINS);
   localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(OFS_SEL);
   localparam logic [ADDR_W-1:0] A_WIN = ADDR_W'(OFS_WIN);
   localparam logic [ADDR_W-1:0] A_EOI = ADDR_W'(OFS_EOI);
   localparam logic [7:0]        CNT_V = 8'(NPINS - 1);

   if (!(VERSION == 8'h11 || VERSION == 8'h20)) begin : g_bad_version
      $error("irq_route_regs: VERSION must be 8'h11 or 8'h20");
   end
   if (NPINS < 2 || NPINS > 256 || TBL_BASE + 2*NPINS > (1 << SEL_W)) begin : g_bad_pins
      $error("irq_route_regs: NPINS does not fit the select space");
   end
   if (ID_LSB + ID_W > 32 || CNT_LSB + 8 > 32 || CNT_LSB < 8) begin : g_bad_fields
      $error("irq_route_regs: field placement outside the 32-bit word");
   end

   logic [SEL_W-1:0] sel_q;
   logic [ID_W-1:0]  id_q;
   logic             is_id, is_ver, is_ent, upper;
   logic [IDX_W-1:0] idx;
   logic             win_wr;
   logic [ENT_W-1:0] ent_q [NPINS];
   logic [ENT_W-1:0] ent_rd;
   logic [31:0]      win_rd;

   irq_route_sel_dec #(
      .SEL_W(SEL_W), .TBL_BASE(TBL_BASE), .NPINS(NPINS), .IDX_W(IDX_W)
   ) u_dec (
      .sel_i(sel_q), .is_id_o(is_id), .is_ver_o(is_ver), .is_ent_o(is_ent),
      .idx_o(idx), .upper_o(upper)
   );

   assign win_wr = wr_i && (addr_i == A_WIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         id_q  <= '0;
      end else begin
         if (wr_i && addr_i == A_SEL) sel_q <= wdata_i[SEL_W-1:0];
         if (win_wr && is_id)         id_q  <= wdata_i[ID_LSB +: ID_W];
      end
   end

   for (genvar i = 0; i < NPINS; i++) begin : g_ent
      logic hit;
      assign hit = win_wr && is_ent && (idx == IDX_W'(i));
      irq_route_entry u_ent (
         .clk(clk), .rst_n(rst_n),
         .we_lo_i(hit && !upper), .we_hi_i(hit && upper),
         .wdata_i(wdata_i),
         .rirr_set_i(rirr_set_i[i]), .rirr_clr_i(rirr_clr_i[i]),
         .dstat_i(dstat_i[i]),
         .q_o(ent_q[i])
      );
      assign tbl_o[i*ENT_W +: ENT_W] = ent_q[i];
   end

   always_comb begin
      ent_rd = '0;
      for (int i = 0; i < NPINS; i++)
         if (idx == IDX_W'(i)) ent_rd = ent_q[i];
   end

   always_comb begin
      win_rd = '0;
      if (is_id) begin
         win_rd[ID_LSB +: ID_W] = id_q;
      end else if (is_ver) begin
         win_rd[7:0]          = VERSION;
         win_rd[CNT_LSB +: 8] = CNT_V;
      end else if (is_ent) begin
         win_rd = upper ? ent_rd[63:32] : ent_rd[31:0];
      end
   end

   always_comb begin
      if (addr_i == A_SEL)      rdata_o = 32'(sel_q);
      else if (addr_i == A_WIN) rdata_o = win_rd;
      else                      rdata_o = '0;
   end

   if (VERSION == 8'h20) begin : g_eoi
      logic eoi_hit;
      assign eoi_hit = wr_i && (addr_i == A_EOI) && (size_i == SZ_WORD);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            eoi_valid_o  <= 1'b0;
            eoi_vector_o <= '0;
         end else begin
            eoi_valid_o <= eoi_hit;
            if (eoi_hit) eoi_vector_o <= wdata_i[7:0];
         end
      end
   end else begin : g_no_eoi
      assign eoi_valid_o  = 1'b0;
      assign eoi_vector_o = '0;
   end

   AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_i && addr_i == A_SEL) |=> $stable(sel_q)); // R1
   AST_EOI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_valid_o |-> ($past(wr_i) && $past(addr_i) == A_EOI
                       && $past(size_i) == SZ_WORD && VERSION == 8'h20)); // R7
   AST_EOI_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_valid_o |-> (eoi_vector_o == $past(wdata_i[7:0]))); // R7
   AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_i == A_WIN && !is_id && !is_ver && !is_ent) |-> (rdata_o == '0)); // R8
endmodule

// File: tb/tb_irq_route_regs.sv
`timescale 1ns/1ps
module tb_irq_route_regs;
   localparam int NP = 24;
   localparam logic [7:0] A_SEL = 8'h00, A_WIN = 8'h10, A_EOI = 8'h40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        wr = 1'b0;
   logic [1:0]  size = 2'd2;
   logic [NP-1:0] rset = '0, rclr = '0, dstat = '0;
   logic [31:0] rdata, rdata11;
   logic [NP*64-1:0] tbl, tbl11;
   logic eoi_v, eoi_v11;
   logic [7:0] eoi_vec, eoi_vec11;

   int checks = 0, failures = 0;
   bit done = 0;

   always #4 clk = ~clk;

   irq_route_regs dut (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .size_i(size),
      .rdata_o(rdata), .rirr_set_i(rset), .rirr_clr_i(rclr), .dstat_i(dstat),
      .tbl_o(tbl), .eoi_valid_o(eoi_v), .eoi_vector_o(eoi_vec));

   irq_route_regs #(.VERSION(8'h11)) dut_v11 (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .size_i(size),
      .rdata_o(rdata11), .rirr_set_i(rset), .rirr_clr_i(rclr), .dstat_i(dstat),
      .tbl_o(tbl11), .eoi_valid_o(eoi_v11), .eoi_vector_o(eoi_vec11));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] s);
      @(negedge clk);
      addr = a; wdata = d; size = s; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; wr = 1'b0;
      #2 d = rdata;
   endtask

   task automatic win_wr(input logic [7:0] s, input logic [31:0] d);
      bus_wr(A_SEL, 32'(s), 2'd2);
      bus_wr(A_WIN, d, 2'd2);
   endtask

   task automatic win_rd(input logic [7:0] s, output logic [31:0] d);
      bus_wr(A_SEL, 32'(s), 2'd2);
      bus_rd(A_WIN, d);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      bus_rd(A_SEL, d);            chk("R1 select reset", 64'(d), 64'h0);
      chk("R9 entry0 reset", tbl[0 +: 64], 64'h0000_0000_0001_0000);
      chk("R9 entry23 reset", tbl[23*64 +: 64], 64'h0000_0000_0001_0000);
      chk("R7 eoi idle after reset", 64'(eoi_v), 64'h0);
      win_rd(8'h00, d);            chk("R2 id reset", 64'(d), 64'h0);
   endtask

   task automatic t_select_id();
      logic [31:0] d;
      bus_wr(A_SEL, 32'h0000_002A, 2'd2);
      bus_rd(A_SEL, d);            chk("R1 select readback", 64'(d), 64'h2A);
      win_wr(8'h00, 32'hFFFF_FFFF);
      win_rd(8'h00, d);            chk("R2 id field only", 64'(d), 64'h0F00_0000);
   endtask

   task automatic t_version();
      logic [31:0] d;
      win_wr(8'h01, 32'h0000_0000);
      win_rd(8'h01, d);            chk("R3 version word v20", 64'(d), 64'h0017_0020);
      chk("R3 version word v11", 64'(rdata11), 64'h0017_0011);
   endtask

   task automatic t_entry_halves();
      logic [31:0] d;
      win_wr(8'h3F, 32'h1234_5678);
      win_rd(8'h3F, d);            chk("R4 entry23 upper", 64'(d), 64'h1234_5678);
      win_rd(8'h3E, d);            chk("R4 entry23 lower kept", 64'(d), 64'h0001_0000);
      chk("R10 entry23 on table", tbl[23*64 +: 64], 64'h1234_5678_0001_0000);
   endtask

   task automatic t_status_bits();
      logic [31:0] d;
      win_wr(8'h16, 32'h0001_D031);
      win_rd(8'h16, d);            chk("R5 software cannot set status", 64'(d), 64'h0001_8031);
      @(negedge clk) rset = NP'(1) << 3;
      @(negedge clk) rset = '0;
      win_rd(8'h16, d);            chk("R5 remote irr set pulse", 64'(d), 64'h0001_C031);
      win_wr(8'h16, 32'h0001_8031);
      win_rd(8'h16, d);            chk("R5 level write keeps remote irr", 64'(d), 64'h0001_C031);
      win_wr(8'h17, 32'hAB00_0000);
      win_rd(8'h16, d);            chk("R4 upper write keeps lower", 64'(d), 64'h0001_C031);
      @(negedge clk) rclr = NP'(1) << 3;
      @(negedge clk) rclr = '0;
      win_rd(8'h16, d);            chk("R5 remote irr clear pulse", 64'(d), 64'h0001_8031);
      @(negedge clk) dstat = NP'(1) << 7;
      @(negedge clk);
      win_rd(8'h1E, d);            chk("R5 delivery status follows", 64'(d), 64'h0001_1000);
      @(negedge clk) dstat = '0;
   endtask

   task automatic t_edge_clear();
      logic [31:0] d;
      @(negedge clk) rset = NP'(1) << 3;
      @(negedge clk) rset = '0;
      win_rd(8'h16, d);            chk("R5 remote irr set again", 64'(d), 64'h0001_C031);
      win_wr(8'h16, 32'h0000_0031);
      win_rd(8'h16, d);            chk("R6 edge write clears remote irr", 64'(d), 64'h0000_0031);
      chk("R10 entry3 on table", tbl[3*64 +: 64], 64'hAB00_0000_0000_0031);
   endtask

   task automatic t_eoi();
      bus_wr(A_EOI, 32'h0000_0155, 2'd2);
      chk("R7 eoi strobe", 64'(eoi_v), 64'h1);
      chk("R7 eoi vector", 64'(eoi_vec), 64'h55);
      chk("R7 eoi absent in v11", 64'(eoi_v11), 64'h0);
      @(negedge clk);
      chk("R7 eoi one cycle", 64'(eoi_v), 64'h0);
      bus_wr(A_EOI, 32'h0000_0066, 2'd0);
      chk("R7 byte eoi ignored", 64'(eoi_v), 64'h0);
   endtask

   task automatic t_out_of_range();
      logic [31:0] d;
      logic [NP*64-1:0] snap;
      snap = tbl;
      win_wr(8'h40, 32'hFFFF_FFFF);
      win_wr(8'h05, 32'hFFFF_FFFF);
      win_wr(8'h0F, 32'hFFFF_FFFF);
      chk("R8 table unchanged lo", tbl[NP*32-1:0] == snap[NP*32-1:0] ? 64'h1 : 64'h0, 64'h1);
      chk("R8 table unchanged hi", tbl[NP*64-1:NP*32] == snap[NP*64-1:NP*32] ? 64'h1 : 64'h0, 64'h1);
      win_rd(8'h40, d);            chk("R8 past table reads zero", 64'(d), 64'h0);
      win_rd(8'h0F, d);            chk("R8 gap reads zero", 64'(d), 64'h0);
      win_rd(8'h00, d);            chk("R8 id untouched", 64'(d), 64'h0F00_0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_select_id();
      t_version();
      t_entry_halves();
      t_status_bits();
      t_edge_clear();
      t_eoi();
      t_out_of_range();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule